// File: doc/BRIEF.md
# Receive Sample Width Formatter

The formatter sits between the receive filter chain and the host-bound FIFO. It takes one signed 16-bit I/Q pair per valid strobe and turns it into 16-bit words with a write strobe. A single 32-bit format word configures it. That word sets an arithmetic right shift, a target sample width, whether Q is delivered or only I, and a request to bypass the upstream halfband filter. The bypass request is forwarded to that filter as a registered control output.

Two widths are implemented. The wide mode carries full 16-bit samples, and I is followed by Q in the next cycle. The narrow mode reduces each shifted sample to 8 bits and packs two of them into one word. With Q enabled the word holds I in its low byte and Q in its high byte. In I-only mode the word holds two consecutive I samples, the earlier one in the low byte. Any width code other than 8 is treated as 16. A change of the format word discards a half-filled narrow word, and the new format applies to the next sample.

Top module: `rx_width_fmt`

## Requirements
- R1: During and directly after reset, `wr_o` is 0, `word_o` is 0 and `hb_bypass_o` is 0.
- R2: Before width reduction, each sample is shifted right arithmetically (sign-extended) by `fmt_i[3:0]` positions, from 0 to 15.
- R3: When the width code `fmt_i[8:4]` is 16 and `fmt_i[9]` is 1, a sample accepted at clock edge k writes the shifted I at edge k+1 and the shifted Q at edge k+2. In this mode `valid_i` must stay low in the cycle after an accepted sample.
- R4: When the width code is 16 and `fmt_i[9]` is 0, each accepted sample writes exactly one word, the shifted I, at edge k+1.
- R5: When the width code is 8 and `fmt_i[9]` is 1, each accepted sample writes one word at edge k+1. Bits [7:0] hold the low 8 bits of the shifted I and bits [15:8] hold the low 8 bits of the shifted Q.
- R6: When the width code is 8 and `fmt_i[9]` is 0, I samples are paired. The first sample of a pair writes nothing. The second writes, one edge later, a word with the first sample's 8 bits in [7:0] and the second's in [15:8].
- R7: Any width code other than 8, including 0 and 12, behaves exactly like width 16.
- R8: A change in `fmt_i[10:0]` from one cycle to the next drops any half-filled I-only narrow word. The sample that arrives with or after the change starts a new pair.
- R9: `hb_bypass_o` equals `fmt_i[10]` as sampled at the previous clock edge.
- R10: `fmt_i[31:11]` has no effect on the words, the strobe, the bypass output or the pairing state.
- R11: `wr_o` is asserted only for a word due under R3 to R6. The word count equals exactly the count those rules predict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 32 | Format word: shift [3:0], width [8:4], deliver Q [9], halfband bypass [10] |
| valid_i | input | 1 | Sample pair present on `i_i`/`q_i` |
| i_i | input | 16 | Signed in-phase sample |
| q_i | input | 16 | Signed quadrature sample |
| word_o | output | 16 | Output word to the FIFO |
| wr_o | output | 1 | Write strobe for `word_o` |
| hb_bypass_o | output | 1 | Registered halfband bypass request |

## Verification
Each word is due one edge after the sample that completes it, and the second wide word is due two edges after its sample. The bypass output follows the format word by one edge. The driver applies inputs on the falling edge. As it does so it pushes the words predicted by the requirement rules into a queue. The monitor samples `wr_o` and `word_o` on each later falling edge, so a word is compared exactly one half period after the edge that produced it, and any strobe with an empty queue fails under R11. The driver leaves an idle cycle after every sample so that the wide Q word has its slot. A queue left non-empty at the end also counts as a failure.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int FMT_W     = 32;
  localparam int SHIFT_LSB = 0;
  localparam int SHIFT_W   = 4;
  localparam int WIDTH_LSB = 4;
  localparam int WIDTH_W   = 5;
  localparam int IQ_BIT    = 9;
  localparam int HB_BIT    = 10;
  localparam int KEY_W     = 11;

  typedef enum logic [1:0] {
    MODE_WIDE_IQ   = 2'd0,
    MODE_WIDE_I    = 2'd1,
    MODE_NARROW_IQ = 2'd2,
    MODE_NARROW_I  = 2'd3
  } mode_e;

  function automatic mode_e pick_mode(input logic [WIDTH_W-1:0] width,
                                      input logic iq,
                                      input logic [WIDTH_W-1:0] narrow_code);
    mode_e m;
    if (width == narrow_code) m = iq ? MODE_NARROW_IQ : MODE_NARROW_I;
    else                      m = iq ? MODE_WIDE_IQ   : MODE_WIDE_I;
    return m;
  endfunction
endpackage

// File: rtl/rwf_fmt_decode.sv
module rwf_fmt_decode
  import rwf_pkg::*;
#(
  parameter int NARROW_W = 8
) (
  input  logic [FMT_W-1:0]   fmt_i,
  output mode_e              mode_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               hb_o,
  output logic [KEY_W-1:0]   key_o
);
  localparam logic [WIDTH_W-1:0] NarrowCode = WIDTH_W'(NARROW_W);

  // reserved field is ignored on purpose
  logic unused_rsvd;
  assign unused_rsvd = ^fmt_i[FMT_W-1:KEY_W];

  assign mode_o  = pick_mode(fmt_i[WIDTH_LSB +: WIDTH_W], fmt_i[IQ_BIT], NarrowCode);
  assign shift_o = fmt_i[SHIFT_LSB +: SHIFT_W];
  assign hb_o    = fmt_i[HB_BIT];
  assign key_o   = fmt_i[KEY_W-1:0];
endmodule

// File: rtl/rwf_scaler.sv
module rwf_scaler
  import rwf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 2,
  localparam int NarrowW = SAMPLE_W / 2
) (
  input  logic [LANES*SAMPLE_W-1:0] smp_i,
  input  logic [SHIFT_W-1:0]        shift_i,
  output logic [LANES*SAMPLE_W-1:0] wide_o,
  output logic [LANES*NarrowW-1:0]  narrow_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [SAMPLE_W-1:0] sh;
    assign sh = $signed(smp_i[g*SAMPLE_W +: SAMPLE_W]) >>> shift_i;
    assign wide_o[g*SAMPLE_W +: SAMPLE_W] = sh;
    assign narrow_o[g*NarrowW +: NarrowW] = sh[NarrowW-1:0];
  end
endmodule

// File: rtl/rwf_packer.sv
module rwf_packer
  import rwf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int HalfW   = SAMPLE_W / 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  mode_e                 mode_i,
  input  logic [2*SAMPLE_W-1:0] wide_i,    // {Q, I}
  input  logic [SAMPLE_W-1:0]   narrow_i,  // {Q8, I8}
  input  logic [KEY_W-1:0]      key_i,
  input  logic                  hb_req_i,
  output logic [SAMPLE_W-1:0]   word_o,
  output logic                  wr_o,
  output logic                  hb_o
);
  logic [SAMPLE_W-1:0] word_q, pend_word_q;
  logic                wr_q, pend_q, hb_q;
  logic [HalfW-1:0]    half_q;
  logic                half_vld_q;
  logic [KEY_W-1:0]    key_q;
  logic                key_chg;

  assign key_chg = (key_i != key_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= '0;
      pend_word_q <= '0;
      wr_q        <= 1'b0;
      pend_q      <= 1'b0;
      hb_q        <= 1'b0;
      half_q      <= '0;
      half_vld_q  <= 1'b0;
      key_q       <= '0;
    end else begin
      key_q <= key_i;
      hb_q  <= hb_req_i;
      wr_q  <= 1'b0;
      if (key_chg) half_vld_q <= 1'b0;
      // second word of a wide I/Q pair
      if (pend_q) begin
        word_q <= pend_word_q;
        wr_q   <= 1'b1;
        pend_q <= 1'b0;
      end
      if (valid_i) begin
        unique case (mode_i)
          MODE_WIDE_IQ: begin
            word_q      <= wide_i[SAMPLE_W-1:0];
            wr_q        <= 1'b1;
            pend_q      <= 1'b1;
            pend_word_q <= wide_i[2*SAMPLE_W-1:SAMPLE_W];
          end
          MODE_WIDE_I: begin
            word_q <= wide_i[SAMPLE_W-1:0];
            wr_q   <= 1'b1;
          end
          MODE_NARROW_IQ: begin
            word_q <= narrow_i;
            wr_q   <= 1'b1;
          end
          MODE_NARROW_I: begin
            if (half_vld_q && !key_chg) begin
              word_q     <= {narrow_i[HalfW-1:0], half_q};
              wr_q       <= 1'b1;
              half_vld_q <= 1'b0;
            end else begin
              half_q     <= narrow_i[HalfW-1:0];
              half_vld_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign word_o = word_q;
  assign wr_o   = wr_q;
  assign hb_o   = hb_q;
endmodule

// File: rtl/rx_width_fmt.sv
module rx_width_fmt
  import rwf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int NarrowW = SAMPLE_W / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FMT_W-1:0]    fmt_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] i_i,
  input  logic [SAMPLE_W-1:0] q_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                wr_o,
  output logic                hb_bypass_o
);
  mode_e                 mode;
  logic [SHIFT_W-1:0]    shift;
  logic                  hb_req;
  logic [KEY_W-1:0]      key;
  logic [2*SAMPLE_W-1:0] wide;
  logic [2*NarrowW-1:0]  narrow;

  rwf_fmt_decode #(.NARROW_W(NarrowW)) u_dec (
    .fmt_i  (fmt_i),
    .mode_o (mode),
    .shift_o(shift),
    .hb_o   (hb_req),
    .key_o  (key)
  );

  rwf_scaler #(.SAMPLE_W(SAMPLE_W), .LANES(2)) u_scl (
    .smp_i   ({q_i, i_i}),
    .shift_i (shift),
    .wide_o  (wide),
    .narrow_o(narrow)
  );

  rwf_packer #(.SAMPLE_W(SAMPLE_W)) u_pck (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .mode_i  (mode),
    .wide_i  (wide),
    .narrow_i(narrow),
    .key_i   (key),
    .hb_req_i(hb_req),
    .word_o  (word_o),
    .wr_o    (wr_o),
    .hb_o    (hb_bypass_o)
  );
endmodule

// File: rtl/rwf_checker.sv
module rwf_checker
  import rwf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int NarrowW = SAMPLE_W / 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [FMT_W-1:0]    fmt_i,
  input logic                valid_i,
  input logic [SAMPLE_W-1:0] i_i,
  input logic [SAMPLE_W-1:0] q_i,
  input logic [SAMPLE_W-1:0] word_o,
  input logic                wr_o,
  input logic                hb_bypass_o
);
  logic signed [SAMPLE_W-1:0] i_sh, q_sh;
  logic narrow, iq, wide_iq_d, seen;
  logic unused_hi;

  assign unused_hi = ^fmt_i[FMT_W-1:KEY_W];
  assign i_sh   = $signed(i_i) >>> fmt_i[SHIFT_LSB +: SHIFT_W];
  assign q_sh   = $signed(q_i) >>> fmt_i[SHIFT_LSB +: SHIFT_W];
  assign narrow = (fmt_i[WIDTH_LSB +: WIDTH_W] == WIDTH_W'(NarrowW));
  assign iq     = fmt_i[IQ_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_iq_d <= 1'b0;
      seen      <= 1'b0;
    end else begin
      wide_iq_d <= valid_i && !narrow && iq;
      seen      <= 1'b1;
    end
  end

  p_wide_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !narrow) |=> (wr_o && word_o == $past(i_sh)));

  p_wide_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !narrow && iq) |=> ##1 (wr_o && word_o == $past(q_sh, 2)));

  p_narrow_iq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && narrow && iq) |=>
      (wr_o && word_o == {$past(q_sh[NarrowW-1:0]), $past(i_sh[NarrowW-1:0])}));

  p_hb_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (hb_bypass_o == $past(fmt_i[HB_BIT])));

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !wide_iq_d) |=> !wr_o);
endmodule

bind rx_width_fmt rwf_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fmt_i      (fmt_i),
  .valid_i    (valid_i),
  .i_i        (i_i),
  .q_i        (q_i),
  .word_o     (word_o),
  .wr_o       (wr_o),
  .hb_bypass_o(hb_bypass_o)
);

// File: tb/sim_rx_width_fmt.sv
module sim_rx_width_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fmt = '0;
  logic        valid = 1'b0;
  logic [15:0] si = '0, sq = '0;
  logic [15:0] word;
  logic        wr, hb;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  // model state
  logic [10:0] last_key = '0;
  bit          half_v = 0;
  logic [7:0]  half_b = '0;

  always #5 clk = ~clk;

  rx_width_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .valid_i(valid),
    .i_i(si), .q_i(sq), .word_o(word), .wr_o(wr), .hb_bypass_o(hb)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic note_key(input logic [31:0] f);
    if (f[10:0] != last_key) half_v = 0;  // R8 model
    last_key = f[10:0];
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && wr) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected write", {16'h0, word}, 32'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(word === e, t, {16'h0, word}, {16'h0, e});
      end
    end
  end

  task automatic send(input logic [31:0] f, input logic [15:0] a, b, input string tag);
    logic signed [15:0] sa, sb;
    logic [31:0] m;
    m = f & 32'h0000_07FF;  // R10: reserved bits ignored by model
    @(negedge clk);
    fmt = f; valid = 1'b1; si = a; sq = b;
    note_key(m);
    sa = $signed(a) >>> m[3:0];
    sb = $signed(b) >>> m[3:0];
    if (m[8:4] != 5'd8) begin
      push(sa, tag);
      if (m[9]) push(sb, tag);
    end else if (m[9]) begin
      push({sb[7:0], sa[7:0]}, tag);
    end else if (half_v) begin
      push({sa[7:0], half_b}, tag);
      half_v = 0;
    end else begin
      half_b = sa[7:0];
      half_v = 1;
    end
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_fmt(input logic [31:0] f);
    @(negedge clk);
    fmt = f;
    note_key(f & 32'h0000_07FF);
    @(negedge clk);
  endtask

  localparam logic [31:0] F_W16_IQ = 32'h0000_0300;
  localparam logic [31:0] F_W16_I  = 32'h0000_0100;
  localparam logic [31:0] F_W8_IQ  = 32'h0000_0288;
  localparam logic [31:0] F_W8_I   = 32'h0000_0088;
  localparam logic [31:0] HB       = 32'h0000_0400;

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wr === 1'b0 && word === 16'h0 && hb === 1'b0, "R1 in reset", {word, 15'h0, wr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr === 1'b0 && hb === 1'b0, "R1 after reset", {30'h0, hb, wr}, 32'h0);

    // R3 wide I then Q
    send(F_W16_IQ, 16'h1234, 16'hABCD, "R3 wide iq");
    send(F_W16_IQ, 16'h8000, 16'h7FFF, "R3 wide iq extremes");
    // R2 arithmetic shift
    send(F_W16_IQ | 32'd3, 16'hF000, 16'h0F00, "R2 shift 3");
    send(F_W16_IQ | 32'd15, 16'h8001, 16'h7FFF, "R2 shift 15");
    // R4 wide I only
    send(F_W16_I, 16'h5A5A, 16'hFFFF, "R4 wide i");
    send(F_W16_I | 32'd4, 16'hC350, 16'h0001, "R4 wide i shift");
    // R5 narrow iq, shift 8
    send(F_W8_IQ, 16'h12FF, 16'hA055, "R5 narrow iq");
    send(F_W8_IQ, 16'h8000, 16'h7F00, "R5 narrow iq signs");
    // R6 narrow i pairing
    send(F_W8_I, 16'h1100, 16'h0, "R6 pair a");
    send(F_W8_I, 16'h2200, 16'h0, "R6 pair a");
    send(F_W8_I, 16'hF300, 16'h0, "R6 pair b");
    send(F_W8_I, 16'h8400, 16'h0, "R6 pair b");
    // R7 unsupported widths
    send(32'h0000_02C0, 16'h0BAD, 16'hBEEF, "R7 width 12");
    send(32'h0000_0200, 16'hCAFE, 16'h0042, "R7 width 0");
    send(32'h0000_0082, 16'h4444, 16'h0, "R7 width 8 vs 24 i-only start");
    send(32'h0000_0182, 16'h4444, 16'h0, "R7 width 24 i-only");
    // R8 format change drops half word
    send(F_W8_I, 16'h7700, 16'h0, "R8 dropped half");
    send(F_W8_I | 32'd9, 16'h6600, 16'h0, "R8 new pair");
    send(F_W8_I | 32'd9, 16'h5400, 16'h0, "R8 new pair");
    send(F_W8_I, 16'h3300, 16'h0, "R8 idle change");
    set_fmt(F_W8_IQ);
    set_fmt(F_W8_I);
    send(F_W8_I, 16'h2200, 16'h0, "R8 after idle change");
    send(F_W8_I, 16'h1100, 16'h0, "R8 after idle change");
    // R9 halfband bypass pass-through
    set_fmt(F_W8_IQ | HB);
    check(hb === 1'b1, "R9 bypass set", {31'h0, hb}, 32'h1);
    send(F_W8_IQ | HB, 16'h0102, 16'h0304, "R9 data with bypass");
    set_fmt(F_W8_IQ);
    check(hb === 1'b0, "R9 bypass clear", {31'h0, hb}, 32'h0);
    // R10 reserved bits ignored
    send(F_W8_I, 16'hAA00, 16'h0, "R10 half");
    send(F_W8_I | 32'hFFFF_F800, 16'hBB00, 16'h0, "R10 pair kept");
    check(hb === 1'b0, "R10 bypass unaffected", {31'h0, hb}, 32'h0);
    send(F_W16_I | 32'h0000_A800, 16'h1357, 16'h0, "R10 wide");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 words outstanding", exp_q.size(), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule